// File: doc/BRIEF.md
# Seven-to-one pixel lane serializer

This block turns one parallel video pixel into four serial data lanes and a clock lane. A pixel has 8-bit red, green and blue plus horizontal sync, vertical sync and data enable. It is spread over 7-bit words, one word per lane. Each word leaves the block one bit per fast clock cycle, so seven fast cycles make one pixel period. The clock lane carries a fixed 7-bit pattern in step with the data words. A receiver can find word boundaries from that pattern.

The block runs entirely on the fast clock. Its internal slot counter defines the pixel period, and `pix_take_o` tells the upstream source when the next pixel is taken. Two static settings choose the layout: a 2-bit map selector and a mirror flag that reverses the slot order on every lane. Both are captured only while reset is held. Electrical signalling, generation of the fast clock and display timing are left to surrounding logic.

Top module: `lvds_lane_serializer`

## Requirements
- R1: The slot counter steps through slots 0 to 6 and wraps. `pix_take_o` is high for exactly one fast cycle in every seven. The pixel inputs are sampled at the rising edge that ends a cycle with `pix_take_o` high. Slot 0 of that pixel appears on the lanes in the next cycle, and slot k appears k cycles later.
- R2: With map selector 0, three lanes carry data and only the upper six bits of each colour are used (bit n below means input bit n+2). Lane 0 sends G0, R5, R4, R3, R2, R1, R0 in slots 0..6. Lane 1 sends B1, B0, G5, G4, G3, G2, G1. Lane 2 sends DE, VS, HS, B5, B4, B3, B2. Lane 3 is held at 0.
- R3: With map selector 1, lanes 0 to 2 match the R2 layout of colour bits 7..2. Lane 3 sends 0, B1, B0, G1, G0, R1, R0 in slots 0..6.
- R4: With map selector 2, lanes 0 to 2 use the R2 layout applied to colour bits 5..0 directly. Lane 3 sends 0, B7, B6, G7, G6, R7, R6 in slots 0..6.
- R5: Horizontal sync, vertical sync and data enable occupy lane 2 slots 2, 1 and 0. Lane 3 slot 0 is always 0.
- R6: With the mirror flag set, every data lane sends its word in slot order 6 down to 0, so slot 6 is sent first.
- R7: The clock lane sends 1,1,0,0,0,1,1 over slots 0..6, mirrored along with the data when the flag is set.
- R8: The map selector and mirror flag are captured only while `rst` is high. Changing them afterwards has no effect on the lanes until the next reset.
- R9: Map selector 3 behaves exactly like map selector 0.
- R10: While `rst` is high, all lanes, the clock lane and `pix_take_o` are 0. In the first cycle after release, `pix_take_o` is 1 and the lanes are still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (7x pixel) clock |
| rst | input | 1 | Synchronous active-high reset; also captures configuration |
| map_mode | input | 2 | Layout selector (0 and 3: 18-bit, 1 and 2: the two 24-bit layouts) |
| mirror_en | input | 1 | Reverse the slot order on all lanes |
| red | input | 8 | Red component |
| green | input | 8 | Green component |
| blue | input | 8 | Blue component |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| de | input | 1 | Data enable |
| pix_take_o | output | 1 | Pixel inputs are sampled at the end of this cycle |
| data_lane_o | output | 4 | Serial data lanes 0..3 |
| clk_lane_o | output | 1 | Serial clock lane pattern |

## Verification
Each layout and mirror combination is driven with pixels that carry exactly one set bit across the 27 input bits. Each of these pixels shows whether that bit lands on the correct lane and slot, and a swap of any two positions shows up. All-ones and all-zeros pixels separate stuck or constant slots, in particular the fixed 0 in lane 3 slot 0. Random pixels under a fixed seed then mix the fields. A separate run changes the layout inputs after reset and expects the layout captured at reset to remain.

// File: rtl/lvds_lane_serializer.sv
module lvds_lane_serializer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    map_mode,
  input  logic          mirror_en,
  input  logic [CW-1:0] red,
  input  logic [CW-1:0] green,
  input  logic [CW-1:0] blue,
  input  logic          hsync,
  input  logic          vsync,
  input  logic          de,
  output logic          pix_take_o,
  output logic [3:0]    data_lane_o,
  output logic          clk_lane_o
);
  localparam int SLOTS = 7;
  localparam int LANES = 4;
  localparam int SW    = $clog2(SLOTS);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);
  localparam logic [SLOTS-1:0] CLK_PAT = 7'b1100011;

  logic [SW-1:0] slot_q;
  logic [1:0]    mode_q;
  logic          mirror_q;
  logic [SLOTS-1:0] ck_q;
  logic [LANES-1:0][SLOTS-1:0] sh_q;
  logic [LANES-1:0][SLOTS-1:0] word;
  logic [5:0] r6, g6, b6;

  function automatic logic [SLOTS-1:0] flip(input logic [SLOTS-1:0] v);
    for (int i = 0; i < SLOTS; i++) flip[i] = v[SLOTS-1-i];
  endfunction

  wire load     = (slot_q == LAST);
  wire low_bits = (mode_q == 2'd2);

  assign r6 = low_bits ? red[5:0]   : red[CW-1:CW-6];
  assign g6 = low_bits ? green[5:0] : green[CW-1:CW-6];
  assign b6 = low_bits ? blue[5:0]  : blue[CW-1:CW-6];

  // Vectors are written slot 0 first (MSB) through slot 6 (LSB).
  always_comb begin
    word[0] = {g6[0], r6};
    word[1] = {b6[1:0], g6[5:1]};
    word[2] = {de, vsync, hsync, b6[5:2]};
    case (mode_q)
      2'd1:    word[3] = {1'b0, blue[1:0], green[1:0], red[1:0]};
      2'd2:    word[3] = {1'b0, blue[CW-1:CW-2], green[CW-1:CW-2], red[CW-1:CW-2]};
      default: word[3] = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= LAST;
      mode_q   <= map_mode;
      mirror_q <= mirror_en;
      ck_q     <= '0;
    end else if (load) begin
      slot_q <= '0;
      ck_q   <= mirror_q ? flip(CLK_PAT) : CLK_PAT;
    end else begin
      slot_q <= slot_q + 1'b1;
      ck_q   <= {ck_q[SLOTS-2:0], 1'b0};
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)       sh_q[l] <= '0;
      else if (load) sh_q[l] <= mirror_q ? flip(word[l]) : word[l];
      else           sh_q[l] <= {sh_q[l][SLOTS-2:0], 1'b0};
    end
    assign data_lane_o[l] = sh_q[l][SLOTS-1];
  end

  assign clk_lane_o = ck_q[SLOTS-1];
  assign pix_take_o = load & ~rst;

  p_slot_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    slot_q == LAST |=> slot_q == '0);
  p_slot_step_r1: assert property (@(posedge clk) disable iff (rst)
    slot_q != LAST |=> slot_q == $past(slot_q) + 1'b1);
  p_take_single_r1: assert property (@(posedge clk) disable iff (rst)
    pix_take_o |=> !pix_take_o);
  p_lane3_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd0 || mode_q == 2'd3) |-> !data_lane_o[3]);
  p_ctl3_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ((slot_q == '0 && !mirror_q) || (slot_q == LAST && mirror_q)) |-> !data_lane_o[3]);
  p_clk_mid_low_r7: assert property (@(posedge clk) disable iff (rst)
    (slot_q >= 3'd2 && slot_q <= 3'd4) |-> !clk_lane_o);
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q) && $stable(mirror_q));
endmodule

// File: tb/test_lvds_lane_serializer.sv
module test_lvds_lane_serializer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] map_mode = 2'd0;
  logic mirror_en = 1'b0;
  logic [7:0] red = '0, green = '0, blue = '0;
  logic hsync = 1'b0, vsync = 1'b0, de = 1'b0;
  logic pix_take_o, clk_lane_o;
  logic [3:0] data_lane_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [26:0] cur;

  lvds_lane_serializer i_lvds_lane_serializer (
    .clk(clk), .rst(rst), .map_mode(map_mode), .mirror_en(mirror_en),
    .red(red), .green(green), .blue(blue), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_take_o(pix_take_o), .data_lane_o(data_lane_o), .clk_lane_o(clk_lane_o)
  );

  always #2 clk = ~clk;

  // p = {r[7:0], g[7:0], b[7:0], hs, vs, de}
  function automatic logic exp_bit(input logic [1:0] m, input int lane, input int s,
                                   input logic [26:0] p);
    logic [7:0] r, g, b;
    int off, hi;
    r = p[26:19]; g = p[18:11]; b = p[10:3];
    off = (m == 2'd2) ? 0 : 2;
    hi  = (m == 2'd2) ? 6 : 0;
    case (lane)
      0: return (s == 0) ? g[off] : r[off + 6 - s];
      1: return (s == 0) ? b[off + 1] : (s == 1) ? b[off] : g[off + 7 - s];
      2: return (s == 0) ? p[0] : (s == 1) ? p[1] : (s == 2) ? p[2] : b[off + 8 - s];
      default: begin
        if (m == 2'd0 || m == 2'd3 || s == 0) return 1'b0;
        case (s)
          1: return b[hi + 1];
          2: return b[hi];
          3: return g[hi + 1];
          4: return g[hi];
          5: return r[hi + 1];
          default: return r[hi];
        endcase
      end
    endcase
  endfunction

  function automatic logic [4:0] exp_slot(input logic [1:0] m, input logic mir,
                                          input int k, input logic [26:0] p);
    int s;
    logic [4:0] v;
    s = mir ? 6 - k : k;
    v[4] = (s <= 1 || s >= 5);
    for (int l = 0; l < 4; l++) v[l] = exp_bit(m, l, s, p);
    return v;
  endfunction

  function automatic logic [26:0] make_pix(input int i);
    if (i < 27) return 27'd1 << i;
    if (i == 27) return '1;
    if (i == 28) return '0;
    return 27'($urandom);
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [26:0] p);
    {red, green, blue, hsync, vsync, de} = p;
  endtask

  // Reset with cfg (m, mir); run with expected cfg (em, emir); optionally
  // change the configuration inputs after release (R8).
  task automatic run(input logic [1:0] m, input logic mir, input logic [1:0] em,
                     input logic emir, input bit poke, input int npix, input string req);
    logic [26:0] p;
    @(negedge clk);
    rst = 1'b1; map_mode = m; mirror_en = mir; drive('1);
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {clk_lane_o, data_lane_o}, 5'b0);
    check("R10 reset take", {4'b0, pix_take_o}, 5'b0);
    rst = 1'b0;
    #1;
    if (poke) begin map_mode = ~m; mirror_en = ~mir; end
    check("R10 first take", {4'b0, pix_take_o}, 5'b1);
    check("R10 lanes idle", {clk_lane_o, data_lane_o}, 5'b0);
    p = make_pix(0);
    cur = p;
    drive(p);
    for (int i = 1; i <= npix; i++) begin
      for (int k = 0; k < 7; k++) begin
        @(negedge clk);
        check(req, {clk_lane_o, data_lane_o}, exp_slot(em, emir, k, cur));
        check("R1 take strobe", {4'b0, pix_take_o}, {4'b0, (k == 6)});
        if (k == 6) begin
          p = make_pix(i);
          cur = p;
          drive(p);
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 60, "R2 R5 R7 18-bit layout");
    run(2'd1, 1'b0, 2'd1, 1'b0, 1'b0, 60, "R3 R5 24-bit high-first layout");
    run(2'd2, 1'b0, 2'd2, 1'b0, 1'b0, 60, "R4 R5 24-bit low-first layout");
    run(2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 40, "R9 selector 3");
    run(2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 40, "R6 R7 mirrored 18-bit");
    run(2'd1, 1'b1, 2'd1, 1'b1, 1'b0, 40, "R6 mirrored 24-bit high");
    run(2'd2, 1'b1, 2'd2, 1'b1, 1'b0, 40, "R6 mirrored 24-bit low");
    run(2'd1, 1'b0, 2'd1, 1'b0, 1'b1, 40, "R8 config held");
    run(2'd2, 1'b1, 2'd2, 1'b1, 1'b1, 40, "R8 config held mirrored");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule